// File: doc/BRIEF.md
# Frame Buffer Read Pointer Controller

This block generates the read address for a frame memory on the memory's read clock. While reads are enabled (active-low enable), the address steps through the memory one location per cycle and wraps at the end of the memory. The current read address and a strobe marking enabled read cycles are its outputs.

Two active-low controls move the pointer. The clear control returns it to address zero. The set control reloads it from one of three places: the captured write position (a mark value supplied by the write side), a preset read address held by the caller, or an external 24-bit address port. The external port is read as a row/column pair and mapped to a linear address through a programmable line length. Each control can be configured to act only on the cycle of its falling edge, or on every cycle it is held low. Edge mode lets a sync pulse restart the read pointer once per frame. Level mode gives continuous random-access reads.

Top module: `rptr_ctrl`

## Requirements
- R1: After reset, and while reset is held, `rd_addr` is 0 and `rd_valid` is 0.
- R2: On a clock edge with `ren_n` high, `rd_addr` holds its value and `rd_valid` goes to 0. Clear and set have no effect on that edge.
- R3: On a clock edge with `ren_n` low and no active clear or set, `rd_addr` advances by one and `rd_valid` is 1.
- R4: On an edge with `ren_n` low and an active set, `mark_sel` = 0 loads `rd_addr` from `mark_addr`.
- R5: An active set with `mark_sel` = 1 and `addr_sel` = 0 loads `rd_addr` from `preset_addr`.
- R6: An active set with `mark_sel` = 1 and `addr_sel` = 1 loads `rd_addr` from the mapped value of `ext_addr`.
- R7: The mapped value is `ext_addr[23:12] * L + ext_addr[11:0]`. L is `row_len`, and a `row_len` of 0 is taken as 4096.
- R8: On an edge with `ren_n` low and clear active, `rd_addr` becomes 0. Clear wins over a set that is active on the same edge.
- R9: A control configured for level mode (`clr_edge`/`set_edge` = 0) is active on every edge where its pin is low. In edge mode (= 1), it is active only on an edge where the pin is low and was high at the previous edge. The pin is sampled on every edge, whatever the state of `ren_n`.
- R10: Incrementing from DEPTH-1 gives 0. A load target at or above DEPTH loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ren_n | input | 1 | Read enable, active low |
| clr_n | input | 1 | Pointer clear, active low |
| set_n | input | 1 | Pointer set, active low |
| mark_sel | input | 1 | 0: set loads the mark value; 1: set uses `addr_sel` |
| addr_sel | input | 1 | 0: preset register; 1: mapped external address |
| clr_edge | input | 1 | 1: clear acts on falling edge; 0: level |
| set_edge | input | 1 | 1: set acts on falling edge; 0: level |
| row_len | input | 12 | Line length for address mapping; 0 means 4096 |
| mark_addr | input | 24 | Captured write position |
| preset_addr | input | 24 | Preset read address |
| ext_addr | input | 24 | External row (23:12) / column (11:0) address |
| rd_addr | output | AW | Current read address, AW = clog2(DEPTH) |
| rd_valid | output | 1 | High for the cycle after an enabled edge |

## Verification
The bench checks that a set held low in level mode reloads the same address on every cycle, while in edge mode only the first cycle reloads. A design that confused the two would either step away from the target address or keep freezing on it. It checks that clear wins over a simultaneous set, and that a disabled cycle swallows both controls. A wrong priority would show the set target, and a leak would move the pointer. It also covers a line length of 0 mapping to a plain concatenation, the wrap at the last memory location, and the folding of an out-of-range target. A design that got these wrong would show a zero-length product, run past the end of memory, or output an address beyond the memory.

// File: rtl/rptr_pkg.sv
package rptr_pkg;

    localparam int EXT_W  = 24;
    localparam int COL_W  = 12;
    localparam int ROW_W  = EXT_W - COL_W;
    localparam int N_CTRL = 2;

    // index of each control pin in the trigger array
    localparam int IDX_CLR = 0;
    localparam int IDX_SET = 1;

    typedef enum logic [1:0] {
        SRC_MARK   = 2'd0,
        SRC_PRESET = 2'd1,
        SRC_EXT    = 2'd2
    } src_e;

endpackage

// File: rtl/rptr_trig.sv
module rptr_trig (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    input  logic edge_mode_i,
    output logic act_o
);
    typedef struct packed {
        logic prev;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d.prev = pin_ni;
        if (edge_mode_i) begin
            act_o = !pin_ni && st_q.prev;
        end else begin
            act_o = !pin_ni;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && act_o) |=> (!act_o || !edge_mode_i));

endmodule

// File: rtl/rptr_addr_map.sv
module rptr_addr_map
    import rptr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [COL_W-1:0] row_len_i,
    input  logic [EXT_W-1:0] ext_i,
    output logic [EXT_W:0]   mapped_o
);
    localparam int LEN_W = COL_W + 1;

    logic [LEN_W-1:0] eff_len;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [EXT_W:0]   prod;

    always_comb begin
        row = ext_i[EXT_W-1:COL_W];
        col = ext_i[COL_W-1:0];
        if (row_len_i == '0) begin
            eff_len = LEN_W'(1) << COL_W;
        end else begin
            eff_len = {1'b0, row_len_i};
        end
        prod     = (EXT_W+1)'(row) * (EXT_W+1)'(eff_len);
        mapped_o = prod + (EXT_W+1)'(col);
    end

    // R7
    zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_len_i == '0) |-> (mapped_o == {1'b0, ext_i}));

endmodule

// File: rtl/rptr_src_sel.sv
module rptr_src_sel
    import rptr_pkg::*;
#(
    parameter int DEPTH = 3110400,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             mark_sel_i,
    input  logic             addr_sel_i,
    input  logic [EXT_W-1:0] mark_i,
    input  logic [EXT_W-1:0] preset_i,
    input  logic [EXT_W:0]   mapped_i,
    output logic [AW-1:0]    target_o
);
    localparam logic [EXT_W:0] LIMIT = (EXT_W+1)'(DEPTH);

    src_e           src;
    logic [EXT_W:0] raw;

    always_comb begin
        if (!mark_sel_i) begin
            src = SRC_MARK;
        end else if (!addr_sel_i) begin
            src = SRC_PRESET;
        end else begin
            src = SRC_EXT;
        end
        unique case (src)
            SRC_MARK:   raw = {1'b0, mark_i};
            SRC_PRESET: raw = {1'b0, preset_i};
            default:    raw = mapped_i;
        endcase
        if (raw >= LIMIT) begin
            target_o = '0;
        end else begin
            target_o = raw[AW-1:0];
        end
    end

endmodule

// File: rtl/rptr_ctrl.sv
module rptr_ctrl
    import rptr_pkg::*;
#(
    parameter int DEPTH = 3110400,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_n,
    input  logic             clr_n,
    input  logic             set_n,
    input  logic             mark_sel,
    input  logic             addr_sel,
    input  logic             clr_edge,
    input  logic             set_edge,
    input  logic [11:0]      row_len,
    input  logic [23:0]      mark_addr,
    input  logic [23:0]      preset_addr,
    input  logic [23:0]      ext_addr,
    output logic [AW-1:0]    rd_addr,
    output logic             rd_valid
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          valid;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [N_CTRL-1:0] pin_n;
    logic [N_CTRL-1:0] mode;
    logic [N_CTRL-1:0] act;
    logic              clr_act;
    logic              set_act;
    logic [EXT_W:0]    mapped;
    logic [AW-1:0]     target;
    logic [AW-1:0]     incr;

    assign pin_n[IDX_CLR] = clr_n;
    assign pin_n[IDX_SET] = set_n;
    assign mode[IDX_CLR]  = clr_edge;
    assign mode[IDX_SET]  = set_edge;

    for (genvar gi = 0; gi < N_CTRL; gi++) begin : g_trig
        rptr_trig u_trig (
            .clk_i       (clk),
            .rst_ni      (rst_n),
            .pin_ni      (pin_n[gi]),
            .edge_mode_i (mode[gi]),
            .act_o       (act[gi])
        );
    end

    assign clr_act = act[IDX_CLR];
    assign set_act = act[IDX_SET];

    rptr_addr_map u_map (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .row_len_i (row_len),
        .ext_i     (ext_addr),
        .mapped_o  (mapped)
    );

    rptr_src_sel #(.DEPTH(DEPTH), .AW(AW)) u_src (
        .mark_sel_i (mark_sel),
        .addr_sel_i (addr_sel),
        .mark_i     (mark_addr),
        .preset_i   (preset_addr),
        .mapped_i   (mapped),
        .target_o   (target)
    );

    always_comb begin
        if (st_q.ptr == LAST) begin
            incr = '0;
        end else begin
            incr = st_q.ptr + AW'(1);
        end
        st_d = st_q;
        if (ren_n) begin
            st_d.valid = 1'b0;
        end else begin
            st_d.valid = 1'b1;
            if (clr_act) begin
                st_d.ptr = '0;
            end else if (set_act) begin
                st_d.ptr = target;
            end else begin
                st_d.ptr = incr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr   <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr  = st_q.ptr;
    assign rd_valid = st_q.valid;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren_n |=> ($stable(rd_addr) && !rd_valid));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_n && !clr_act && !set_act) |=>
        (rd_valid && rd_addr == (($past(rd_addr) == LAST) ? '0 : $past(rd_addr) + AW'(1))));

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_n && clr_act) |=> (rd_addr == '0));

    // R10
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr <= LAST);

endmodule

// File: tb/tb_rptr_ctrl.sv
`timescale 1ns/1ps
module tb_rptr_ctrl;
    localparam int DEPTH = 3110400;
    localparam int AW    = $clog2(DEPTH);
    localparam int NV    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_n = 1'b1, clr_n = 1'b1, set_n = 1'b1;
    logic          mark_sel = 1'b0, addr_sel = 1'b0;
    logic          clr_edge = 1'b0, set_edge = 1'b0;
    logic [11:0]   row_len = 12'd100;
    logic [23:0]   mark_addr = 24'd1234, preset_addr = 24'd500;
    logic [23:0]   ext_addr = {12'd3, 12'd7};
    logic [AW-1:0] rd_addr;
    logic          rd_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rptr_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ren_n(ren_n), .clr_n(clr_n), .set_n(set_n),
        .mark_sel(mark_sel), .addr_sel(addr_sel), .clr_edge(clr_edge),
        .set_edge(set_edge), .row_len(row_len), .mark_addr(mark_addr),
        .preset_addr(preset_addr), .ext_addr(ext_addr),
        .rd_addr(rd_addr), .rd_valid(rd_valid)
    );

    // {ren_n, clr_n, set_n, mark_sel, addr_sel, exp_valid, exp_addr[23:0]}
    // level mode; mark 1234, preset 500, ext row 3 col 7 with length 100 -> 307
    localparam logic [29:0] VEC [NV] = '{
        {5'b11111, 1'b0, 24'd0},     // R2
        {5'b01111, 1'b1, 24'd1},     // R3
        {5'b01111, 1'b1, 24'd2},     // R3
        {5'b01000, 1'b1, 24'd1234},  // R4
        {5'b01111, 1'b1, 24'd1235},  // R3
        {5'b01010, 1'b1, 24'd500},   // R5
        {5'b01010, 1'b1, 24'd500},   // R9 level set reloads again
        {5'b01111, 1'b1, 24'd501},   // R3
        {5'b01011, 1'b1, 24'd307},   // R6
        {5'b11011, 1'b0, 24'd307},   // R2 set ignored
        {5'b00111, 1'b1, 24'd0},     // R8
        {5'b01111, 1'b1, 24'd1},     // R3
        {5'b00000, 1'b1, 24'd0},     // R8 clear beats set
        {5'b01111, 1'b1, 24'd1},     // R3
        {5'b10111, 1'b0, 24'd1},     // R2 clear ignored
        {5'b01111, 1'b1, 24'd2}      // R3
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 9, 14: return "R2";
            3:        return "R4";
            5:        return "R5";
            6:        return "R9";
            8:        return "R6";
            10, 12:   return "R8";
            default:  return "R3";
        endcase
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] ea, input logic ev);
        n_chk++;
        if (rd_addr !== ea || rd_valid !== ev) begin
            n_fail++;
            $display("FAIL %s: addr=%0d valid=%0b expected addr=%0d valid=%0b",
                     tag, rd_addr, rd_valid, ea, ev);
        end
    endtask

    task automatic step(input logic r, input logic c, input logic s,
                        input logic ms, input logic as);
        @(negedge clk);
        ren_n = r; clr_n = c; set_n = s; mark_sel = ms; addr_sel = as;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: addr=%0d valid=%0b expected run to end", rd_addr, rd_valid);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", '0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25]);
            check(vec_tag(i), AW'(VEC[i][23:0]), VEC[i][24]);
        end

        // R7: zero length means 4096
        row_len = 12'd0;
        step(0, 1, 0, 1, 1);
        check("R7 len0", AW'(3 * 4096 + 7), 1'b1);
        row_len = 12'd100;
        ext_addr = {12'd0, 12'd4095};
        step(0, 1, 0, 1, 1);
        check("R7 col only", AW'(4095), 1'b1);

        // R10: wrap and fold
        preset_addr = 24'(DEPTH - 1);
        step(0, 1, 0, 1, 0);
        check("R10 load last", AW'(DEPTH - 1), 1'b1);
        step(0, 1, 1, 1, 0);
        check("R10 wrap", '0, 1'b1);
        step(0, 1, 1, 1, 0);
        preset_addr = 24'(DEPTH);
        step(0, 1, 0, 1, 0);
        check("R10 fold", '0, 1'b1);

        // R9: edge-mode set
        set_edge = 1'b1;
        step(0, 1, 1, 0, 0);
        step(0, 1, 0, 0, 0);
        check("R9 edge set first", AW'(1234), 1'b1);
        step(0, 1, 0, 0, 0);
        check("R9 edge set held", AW'(1235), 1'b1);
        step(0, 1, 1, 0, 0);
        check("R9 edge set released", AW'(1236), 1'b1);
        step(0, 1, 0, 0, 0);
        check("R9 edge set again", AW'(1234), 1'b1);
        // R9: edge consumed while disabled
        step(0, 1, 1, 0, 0);
        step(1, 1, 0, 0, 0);
        check("R9 edge while disabled", AW'(1235), 1'b0);
        step(0, 1, 0, 0, 0);
        check("R9 edge lost", AW'(1236), 1'b1);

        // R9: edge-mode clear
        clr_edge = 1'b1;
        step(0, 1, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        check("R9 edge clr", '0, 1'b1);
        step(0, 0, 1, 0, 0);
        check("R9 edge clr held", AW'(1), 1'b1);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", '0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule